// File: doc/BRIEF.md
# Pipelined Multiple-Constant Shift-Add Multiplier

This block accepts one signed 10-bit sample on every clock and returns four fixed multiples of that sample at once: 3x, 13x, 21x and 37x. It has no general multiplier. Every product is built from hard-wired left shifts, adders and subtractors arranged as a graph of five adder vertices. A typical use is as the shared coefficient stage of a full-rate transposed FIR filter, where each tap needs a different constant multiple of the same input.

The graph is two adder levels deep, and a register bank follows each level. Level one forms 3x as (x<<1)+x and 5x as (x<<2)+x. Level two reuses 5x to form 13x, 21x and 37x by adding it to x shifted left by 3, 4 and 5 bits. The 3x value passes through one extra register so that it leaves the block in step with the level-two results.

A valid flag travels alongside the data through two registers. The data path runs whether or not the input is flagged valid. All registers clear to zero on synchronous reset. The block has no state machine. Its only behaviour is a fixed two-stage pipeline, with a new sample accepted and a new product set emitted on every edge.

Top module: `mcm_shiftadd_top`

## Requirements
- R1: While reset is held and on the first cycle after it is released, every product output is zero and out_valid is low.
- R2: out_p3 equals 3 times the in_sample captured two rising edges earlier.
- R3: out_p13 equals 13 times the in_sample captured two rising edges earlier.
- R4: out_p21 equals 21 times the in_sample captured two rising edges earlier.
- R5: out_p37 equals 37 times the in_sample captured two rising edges earlier.
- R6: out_valid equals the in_valid captured two rising edges earlier, and all four products of one sample appear in the same cycle.
- R7: A new sample is accepted on every edge with no stall, so a back-to-back stream yields a matching product set on every consecutive cycle.
- R8: Products are signed 16-bit two's complement values and do not overflow at the input extremes -512 and +511 (for example 37 * -512 = -18944).
- R9: The data path ignores in_valid. Samples presented with in_valid low still give their products two edges later, while out_valid stays low for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_sample as a real sample |
| in_sample | input | 10 | Signed input sample |
| out_valid | output | 1 | in_valid delayed by two cycles |
| out_p3 | output | 16 | Signed 3x product |
| out_p13 | output | 16 | Signed 13x product |
| out_p21 | output | 16 | Signed 21x product |
| out_p37 | output | 16 | Signed 37x product |

## Verification
Every product and the valid flag are due exactly two rising edges after the sample is driven. The first edge loads the level-one registers and the second loads the outputs. The bench drives inputs and samples outputs on the falling edge. A behavioural two-entry history of the driven samples is shifted once per rising edge, so its oldest entry is the expected result at each falling-edge check. Every cycle is compared in this way, including the first cycle after reset, a back-to-back stream, the extreme input values, and samples sent with the valid flag low.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    localparam int IN_W     = 10;
    localparam int GUARD_W  = 6;
    localparam int PROD_W   = IN_W + GUARD_W;
    localparam int N_WIDE   = 3;
    localparam int LATENCY  = 2;

    typedef logic signed [PROD_W-1:0] prod_t;

    function automatic int wide_shift(input int idx);
        return idx + 3;
    endfunction
endpackage

// File: rtl/mcm_level1.sv
module mcm_level1
    import mcm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] x_in,
    output prod_t                  x_q,
    output prod_t                  m3_q,
    output prod_t                  m5_q
);
    prod_t x_ext;
    prod_t m3_d;
    prod_t m5_d;

    always_comb begin
        x_ext = PROD_W'(x_in);
        m3_d  = (x_ext <<< 1) + x_ext;
        m5_d  = (x_ext <<< 2) + x_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q  <= '0;
            m3_q <= '0;
            m5_q <= '0;
        end else begin
            x_q  <= x_ext;
            m3_q <= m3_d;
            m5_q <= m5_d;
        end
    end

    p_m5_over_m3_r3: assert property (@(posedge clk) disable iff (rst)
        (m5_q - m3_q) == (x_q <<< 1));
endmodule

// File: rtl/mcm_level2.sv
module mcm_level2
    import mcm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prod_t x_q,
    input  prod_t m3_q,
    input  prod_t m5_q,
    output prod_t p3_q,
    output prod_t wide_q [N_WIDE]
);
    always_ff @(posedge clk) begin
        if (rst) p3_q <= '0;
        else     p3_q <= m3_q;
    end

    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        prod_t sum_d;
        always_comb sum_d = (x_q <<< wide_shift(g)) + m5_q;
        always_ff @(posedge clk) begin
            if (rst) wide_q[g] <= '0;
            else     wide_q[g] <= sum_d;
        end
    end
endmodule

// File: rtl/mcm_valid_pipe.sv
module mcm_valid_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic v_in,
    output logic v_out
);
    logic [DEPTH-1:0] taps;

    for (genvar s = 0; s < DEPTH; s++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst)         taps[s] <= 1'b0;
            else if (s == 0) taps[s] <= v_in;
            else             taps[s] <= taps[(s == 0) ? 0 : s-1];
        end
    end

    assign v_out = taps[DEPTH-1];
endmodule

// File: rtl/mcm_shiftadd_top.sv
module mcm_shiftadd_top
    import mcm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    output logic                     out_valid,
    output logic signed [PROD_W-1:0] out_p3,
    output logic signed [PROD_W-1:0] out_p13,
    output logic signed [PROD_W-1:0] out_p21,
    output logic signed [PROD_W-1:0] out_p37
);
    prod_t x_q, m3_q, m5_q, p3_q;
    prod_t wide_q [N_WIDE];

    mcm_level1 u_l1 (
        .clk(clk), .rst(rst), .x_in(in_sample),
        .x_q(x_q), .m3_q(m3_q), .m5_q(m5_q)
    );

    mcm_level2 u_l2 (
        .clk(clk), .rst(rst), .x_q(x_q), .m3_q(m3_q), .m5_q(m5_q),
        .p3_q(p3_q), .wide_q(wide_q)
    );

    mcm_valid_pipe #(.DEPTH(LATENCY)) u_vp (
        .clk(clk), .rst(rst), .v_in(in_valid), .v_out(out_valid)
    );

    assign out_p3  = p3_q;
    assign out_p13 = wide_q[0];
    assign out_p21 = wide_q[1];
    assign out_p37 = wide_q[2];

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)           warm <= '0;
        else if (warm < 2) warm <= warm + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (out_valid == 1'b0 && out_p37 == '0 && out_p3 == '0));
    p_p3_r2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> out_p3 == 16'(3 * $past(in_sample, 2)));
    p_p13_r3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> out_p13 == 16'(13 * $past(in_sample, 2)));
    p_p21_r4: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> out_p21 == 16'(21 * $past(in_sample, 2)));
    p_p37_r5: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> out_p37 == 16'(37 * $past(in_sample, 2)));
    p_valid_lat_r6: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> out_valid == $past(in_valid, 2));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (warm == 2 && $past(in_sample, 2) != 0) |->
        (out_p37[PROD_W-1] == $past(in_sample[IN_W-1], 2)));
endmodule

// File: tb/tb_mcm_shiftadd_top.sv
module tb_mcm_shiftadd_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [9:0] in_sample = '0;
    logic out_valid;
    logic signed [15:0] out_p3, out_p13, out_p21, out_p37;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int  h_x [2];
    bit  h_v [2];

    always #4 clk = ~clk;

    mcm_shiftadd_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_p3(out_p3), .out_p13(out_p13),
        .out_p21(out_p21), .out_p37(out_p37)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string ctx);
        chk({"R2 ", ctx}, int'(out_p3),  3  * h_x[1]);
        chk({"R3 ", ctx}, int'(out_p13), 13 * h_x[1]);
        chk({"R4 ", ctx}, int'(out_p21), 21 * h_x[1]);
        chk({"R5 ", ctx}, int'(out_p37), 37 * h_x[1]);
        chk({"R6 ", ctx}, int'(out_valid), int'(h_v[1]));
    endtask

    task automatic step(input bit v, input int x, input string ctx);
        @(negedge clk);
        compare_all(ctx);
        in_valid  = v;
        in_sample = 10'(x);
        @(posedge clk);
        h_x[1] = h_x[0]; h_v[1] = h_v[0];
        h_x[0] = x;      h_v[0] = v;
    endtask

    initial begin
        h_x = '{0, 0}; h_v = '{0, 0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset p3",    int'(out_p3), 0);
        chk("R1 reset p37",   int'(out_p37), 0);
        chk("R1 reset valid", int'(out_valid), 0);
        in_valid = 1'b1; in_sample = 10'sd100;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0; in_sample = '0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 first cycle after reset p13",   int'(out_p13), 0);
        chk("R1 first cycle after reset valid", int'(out_valid), 0);
        in_valid = 1'b0; in_sample = '0;
        @(posedge clk);
        h_x = '{0, 0}; h_v = '{0, 0};

        step(1, 1, "unit");
        step(1, -1, "minus one");
        step(1, 7, "small");
        for (int i = 0; i < 40; i++)
            step(1, ((i * 37 + 11) % 1024) - 512, "R7 stream");
        step(1, -512, "R8 min");
        step(1, 511, "R8 max");
        step(1, -512, "R8 min again");
        step(1, 0, "zero");
        step(0, 123, "R9 invalid");
        step(0, -300, "R9 invalid");
        step(1, 55, "R6 valid after gap");
        step(0, 9, "R9 invalid");
        step(1, -77, "R6 toggle");
        for (int i = 0; i < 20; i++)
            step(i[0], (i * 53) % 500 - 250, "R9 alternating");
        step(0, 0, "drain");
        step(0, 0, "drain");
        step(0, 0, "drain");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule